// File: doc/BRIEF.md
# Programmable Serial Baud Rate Generator

This block produces the oversampling clock enables for a serial transmitter and receiver. Both enables come from one 1.8432 MHz reference clock. Each enable is a one-cycle pulse in the reference clock domain, at sixteen times the selected bit rate. A 4-bit rate code chooses the transmit rate. The code values 1 to 15 select fifteen fixed internal rates. The code value 0 bypasses the internal divider, so every rising edge of an external 16x clock gives one transmit pulse.

A separate receive-source bit sets the receive enable. The receive enable either follows the transmit enable or follows the external clock on its own. This lets the two directions run at different rates. The rate code and the source bit are loaded by a one-cycle write strobe. A program reset strobe returns them to their idle values.

A divisor table is built at elaboration from the reference frequency. Each divisor is round(f_ref / (16 × baud)). Writing a new code reloads the divider at once, so the first pulse at the new rate arrives exactly one divisor period after the write.

Top module: `baud_tick_gen`

## Requirements
- R1: After the reset input is released, the rate code is 0 and the receive source is the transmit path, so `tx_tick` and `rx_tick` stay low while `ext_clk` stays low.
- R2: With rate code 0, each rising edge of `ext_clk` gives exactly one `tx_tick` pulse, one cycle wide. The pulse is high after the third rising `clk` edge that follows the change of `ext_clk`.
- R3: Rate codes 1 to 15 give the divisors 2304, 1536, 1048, 856, 768, 384, 192, 96, 64, 48, 32, 24, 16, 12 and 6, in that order. These are the rates 50, 75, 109.92, 134.58, 150, 300, 600, 1200, 1800, 2400, 3600, 4800, 7200, 9600 and 19200 baud.
- R4: With a nonzero rate code, `tx_tick` is a one-cycle pulse that repeats every divisor cycles.
- R5: A write with `cfg_wr` high loads `cfg_rate` and `cfg_rx_ext` on that edge and reloads the divider. The first `tx_tick` at the new rate is high after the divisor-th edge that follows the write edge, even if the write falls in the middle of a count.
- R6: With `cfg_rx_ext` = 0 stored, `rx_tick` equals `tx_tick` in every cycle.
- R7: With `cfg_rx_ext` = 1 stored, `rx_tick` pulses once for each rising edge of `ext_clk`, with the R2 latency, whatever the rate code.
- R8: A cycle with `prog_rst` high sets the rate code to 0 and the receive source to 0, and clears the divider count and the synchronizer. On the next cycle both ticks are low. `prog_rst` takes priority over `cfg_wr`.
- R9: With a nonzero rate code, `ext_clk` has no effect on `tx_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (1.8432 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_rst | input | 1 | Program reset strobe |
| cfg_wr | input | 1 | Write strobe for the rate code and the receive source |
| cfg_rate | input | 4 | Rate code: 0 selects the external clock, 1 to 15 select the internal rates |
| cfg_rx_ext | input | 1 | Receive source: 0 follows the transmit path, 1 follows the external clock |
| ext_clk | input | 1 | External 16x clock, asynchronous |
| tx_tick | output | 1 | Transmit 16x enable pulse |
| rx_tick | output | 1 | Receive 16x enable pulse |

## Verification
The bench walks all fifteen rate codes and measures the distance from each write to the first pulse. A table entry that is off, or a reload that lands one count early or late, shows up as a wrong interval. A rewrite in the middle of a long count checks that the reload happens at once. A design that waited for the old terminal count would take many times too long.

The bench toggles `ext_clk` while an internal rate is active and expects `tx_tick` to ignore it. It runs the receive path from the external clock while the transmit path runs internally. If the source mux were swapped or tied, the receive pulses would follow the wrong clock.

A program reset given in the middle of a count must silence both outputs on the next cycle and restore the external mode. A design that kept the count or the synchronizer history would give a stray pulse.

// File: rtl/baud_gen_pkg.sv
// Shared constants and elaboration-time divisor arithmetic for the baud
// tick generator. Assumes rate codes are 4 bits wide and code 0 is the bypass.
package baud_gen_pkg;
    localparam int RATE_W    = 4;
    localparam int NUM_CODES = 1 << RATE_W;

    // Bit rate times 100 for each internal code; 0 marks the bypass code.
    function automatic longint baud_x100(input int code);
        case (code)
            1:       return 64'd5000;
            2:       return 64'd7500;
            3:       return 64'd10992;
            4:       return 64'd13458;
            5:       return 64'd15000;
            6:       return 64'd30000;
            7:       return 64'd60000;
            8:       return 64'd120000;
            9:       return 64'd180000;
            10:      return 64'd240000;
            11:      return 64'd360000;
            12:      return 64'd480000;
            13:      return 64'd720000;
            14:      return 64'd960000;
            15:      return 64'd1920000;
            default: return 64'd0;
        endcase
    endfunction

    // Rounded divisor ref_hz / (16 * baud); the bypass code gets 1.
    function automatic longint rate_divisor(input int code, input longint ref_hz);
        longint b;
        b = baud_x100(code);
        if (b == 0) return 64'd1;
        return (ref_hz * 100 + 8 * b) / (16 * b);
    endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
// Holds the rate code and the receive-source bit. A program reset has
// priority over a write. Assumes both strobes are synchronous to clk.
module baud_cfg_reg
    import baud_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [RATE_W-1:0] wr_rate,
    input  logic              wr_rx_ext,
    output logic [RATE_W-1:0] rate_q,
    output logic              rx_ext_q
);
    // Load the fields on a write, return them to idle on either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rate_q   <= '0;
            rx_ext_q <= 1'b0;
        end else if (wr_en) begin
            rate_q   <= wr_rate;
            rx_ext_q <= wr_rx_ext;
        end
    end
endmodule

// File: rtl/baud_divider.sv
// Down-counter that gives a one-cycle pulse every (run_m1 + 1) cycles while
// run is high. A load restarts the count from load_m1 on the same edge.
// Assumes run_m1 is at least 1.
module baud_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [DIV_W-1:0] load_m1,
    input  logic             run,
    input  logic [DIV_W-1:0] run_m1,
    output logic [DIV_W-1:0] cnt_q,
    output logic             tick_q
);
    // Count down, pulse at zero and reload; a load or clear takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_m1;
            tick_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= run_m1;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
            tick_q <= 1'b0;
        end
    end
endmodule

// File: rtl/baud_ext_sync.sv
// Brings an asynchronous clock into the clk domain through STAGES flops and
// gives one registered pulse per rising edge. Assumes the input's high and
// low phases each last at least two clk cycles.
module baud_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic async_in,
    output logic rise_q
);
    logic [STAGES:0] sh_q;

    // Shift the input through the synchronizer and keep one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh_q <= '0;
        else               sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    // Register the rising-edge detect of the synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) rise_q <= 1'b0;
        else               rise_q <= sh_q[STAGES-1] & ~sh_q[STAGES];
    end
endmodule

// File: rtl/baud_tick_gen.sv
// Top of the baud tick generator. It builds the divisor table from REF_HZ,
// runs the internal divider or the external clock path, and steers both
// paths to the transmit and receive enables. Assumes ext_clk runs slower
// than clk / 4.
module baud_tick_gen
    import baud_gen_pkg::*;
#(
    parameter longint REF_HZ      = 64'd1843200,
    parameter int     SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_rst,
    input  logic              cfg_wr,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cfg_rx_ext,
    input  logic              ext_clk,
    output logic              tx_tick,
    output logic              rx_tick
);
    localparam int DIV_W = $clog2(int'(rate_divisor(1, REF_HZ)) + 1);

    logic [RATE_W-1:0] rate_q;
    logic              rx_ext_q;
    logic [DIV_W-1:0]  div_m1_tab [NUM_CODES];
    logic [DIV_W-1:0]  run_m1;
    logic [DIV_W-1:0]  load_m1;
    logic [DIV_W-1:0]  div_cnt;
    logic              div_tick;
    logic              ext_tick;

    // One constant table entry per rate code, computed at elaboration.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
        assign div_m1_tab[g] = DIV_W'(rate_divisor(g, REF_HZ) - 1);
    end

    baud_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (prog_rst),
        .wr_en     (cfg_wr),
        .wr_rate   (cfg_rate),
        .wr_rx_ext (cfg_rx_ext),
        .rate_q    (rate_q),
        .rx_ext_q  (rx_ext_q)
    );

    // Look up the running divisor and the divisor for a pending write.
    always_comb begin
        run_m1  = div_m1_tab[rate_q];
        load_m1 = div_m1_tab[cfg_rate];
    end

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (prog_rst),
        .load    (cfg_wr),
        .load_m1 (load_m1),
        .run     (rate_q != '0),
        .run_m1  (run_m1),
        .cnt_q   (div_cnt),
        .tick_q  (div_tick)
    );

    baud_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (prog_rst),
        .async_in (ext_clk),
        .rise_q   (ext_tick)
    );

    // Steer the internal and external paths to the two enables.
    always_comb begin
        tx_tick = (rate_q == '0) ? ext_tick : div_tick;
        rx_tick = rx_ext_q ? ext_tick : tx_tick;
    end
endmodule

// File: rtl/baud_tick_gen_chk.sv
// Checker for baud_tick_gen, attached to every instance through the bind
// below. It watches the ports, the stored rate code and the divider count.
module baud_tick_gen_chk #(
    parameter int RW = 4,
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_rst,
    input logic          cfg_wr,
    input logic [RW-1:0] cfg_rate,
    input logic          tx_tick,
    input logic          rx_tick,
    input logic [RW-1:0] rate_q,
    input logic [DW-1:0] div_cnt,
    input logic [DW-1:0] run_m1
);
    // R4: a transmit pulse lasts one cycle when no write or program reset intervenes.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tick && !cfg_wr && !prog_rst) |=> !tx_tick);

    // R5: a write of an internal rate restarts the count, so no pulse follows at once.
    a_r5_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !prog_rst && cfg_rate != '0) |=> !tx_tick);

    // R8: a program reset silences both enables on the next cycle.
    a_r8_prog_reset: assert property (@(posedge clk) disable iff (!rst_n)
        prog_rst |=> (!tx_tick && !rx_tick && rate_q == '0));

    // R3: the running count never exceeds the divisor of the stored code.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q != '0) |-> (div_cnt <= run_m1));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.RW(baud_gen_pkg::RATE_W), .DW(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_rst (prog_rst),
    .cfg_wr   (cfg_wr),
    .cfg_rate (cfg_rate),
    .tx_tick  (tx_tick),
    .rx_tick  (rx_tick),
    .rate_q   (rate_q),
    .div_cnt  (div_cnt),
    .run_m1   (run_m1)
);

// File: tb/baud_tick_gen_tb.sv
// Bench for baud_tick_gen: a behavioural model compared on every clock,
// plus directed interval and latency checks.
module baud_tick_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_rst = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_rate = 4'd0;
    logic       cfg_rx_ext = 1'b0;
    logic       ext_clk = 1'b0;
    logic       tx_tick, rx_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .prog_rst(prog_rst), .cfg_wr(cfg_wr),
        .cfg_rate(cfg_rate), .cfg_rx_ext(cfg_rx_ext), .ext_clk(ext_clk),
        .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    // Expected divisors per rate code (R3).
    function automatic int exp_div(input int code);
        int t[16] = '{1, 2304, 1536, 1048, 856, 768, 384, 192, 96, 64, 48, 32, 24, 16, 12, 6};
        return t[code];
    endfunction

    // Behavioural model state.
    int m_rate = 0;
    bit m_rxe  = 1'b0;
    int m_cnt  = 0;
    bit m_dt   = 1'b0;
    bit m_et   = 1'b0;
    bit m_h[$] = '{1'b0, 1'b0, 1'b0};

    always @(posedge clk) begin
        if (!rst_n || prog_rst) begin
            m_rate = 0; m_rxe = 1'b0; m_cnt = 0; m_dt = 1'b0; m_et = 1'b0;
            m_h = '{1'b0, 1'b0, 1'b0};
        end else begin
            m_et = m_h[1] && !m_h[2];
            m_h.push_front(ext_clk);
            void'(m_h.pop_back());
            if (cfg_wr) begin
                m_rate = int'(cfg_rate); m_rxe = cfg_rx_ext;
                m_cnt = exp_div(m_rate) - 1; m_dt = 1'b0;
            end else if (m_rate == 0) begin
                m_cnt = 0; m_dt = 1'b0;
            end else if (m_cnt == 0) begin
                m_cnt = exp_div(m_rate) - 1; m_dt = 1'b1;
            end else begin
                m_cnt--; m_dt = 1'b0;
            end
        end
    end

    // Compare outputs with the model on every clock, away from the edge.
    always @(negedge clk) begin
        bit etx, erx;
        if (rst_n && !done) begin
            etx = (m_rate == 0) ? m_et : m_dt;
            erx = m_rxe ? m_et : etx;
            checks++;
            if (tx_tick !== etx || rx_tick !== erx) begin
                errors++;
                $display("FAIL R4/R6/R7 model t=%0t: tx=%0b rx=%0b expected tx=%0b rx=%0b",
                         $time, tx_tick, rx_tick, etx, erx);
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic report();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic write_cfg(input int code, input bit rxe);
        cfg_rate = 4'(code); cfg_rx_ext = rxe; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Count negedges until tx_tick is seen high (limit bounds the wait).
    task automatic cycles_to_tx(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!tx_tick && n < limit);
    endtask

    task automatic cycles_to_rx(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!rx_tick && n < limit);
    endtask

    // Toggle ext_clk for a number of periods, counting pulses on both outputs.
    task automatic ext_run(input int periods, output int ntx, output int nrx);
        ntx = 0; nrx = 0;
        for (int p = 0; p < periods; p++) begin
            ext_clk = 1'b1;
            repeat (4) begin @(negedge clk); ntx += int'(tx_tick); nrx += int'(rx_tick); end
            ext_clk = 1'b0;
            repeat (4) begin @(negedge clk); ntx += int'(tx_tick); nrx += int'(rx_tick); end
        end
    endtask

    initial begin
        int n, a, b, ntx, nrx;
        repeat (3) @(negedge clk);
        check("R1 tx during reset", int'(tx_tick), 0);
        rst_n = 1'b1;
        n = 0;
        repeat (10) begin @(negedge clk); n += int'(tx_tick) + int'(rx_tick); end
        check("R1 idle ticks after reset", n, 0);

        // R2: external mode latency and one pulse per edge.
        ext_clk = 1'b1;
        cycles_to_tx(10, n);
        check("R2 ext latency", n, 3);
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        ext_run(10, ntx, nrx);
        check("R2 ext pulse count", ntx, 10);
        check("R6 rx follows tx in ext mode", nrx, 10);

        // R3 / R5: every code, first tick one divisor after the write.
        for (int c = 1; c < 16; c++) begin
            write_cfg(c, 1'b0);
            cycles_to_tx(3000, n);
            check($sformatf("R3 R5 code %0d first tick", c), n, exp_div(c));
        end

        // R4: steady period at code 15, then code 9.
        write_cfg(15, 1'b0);
        cycles_to_tx(100, a);
        cycles_to_tx(100, b);
        check("R4 period code 15", b, 6);
        write_cfg(9, 1'b0);
        cycles_to_tx(200, a);
        cycles_to_tx(200, b);
        check("R4 period code 9", b, 64);

        // R5: a rewrite in the middle of a long count reloads at once.
        write_cfg(1, 1'b0);
        repeat (100) @(negedge clk);
        write_cfg(14, 1'b0);
        cycles_to_tx(3000, n);
        check("R5 mid-count rewrite", n, 12);

        // R9: ext_clk is ignored while an internal rate is active.
        write_cfg(13, 1'b0);
        ext_run(12, ntx, nrx);
        check("R9 tx pulses with ext toggling", ntx, 96 / 16);
        check("R6 rx equals tx internal", nrx, ntx);

        // R7: receive from external clock while transmit runs internally.
        write_cfg(13, 1'b1);
        ext_run(12, ntx, nrx);
        check("R7 rx pulses from ext", nrx, 12);
        check("R7 tx stays internal", ntx, 96 / 16);
        ext_clk = 1'b1;
        cycles_to_rx(10, n);
        check("R7 rx latency", n, 3);
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);

        // R8: program reset in the middle of a count, with a write on the same cycle.
        write_cfg(2, 1'b1);
        repeat (50) @(negedge clk);
        prog_rst = 1'b1; cfg_wr = 1'b1; cfg_rate = 4'd15;
        @(negedge clk);
        prog_rst = 1'b0; cfg_wr = 1'b0;
        check("R8 tx low after program reset", int'(tx_tick), 0);
        n = 0;
        repeat (40) begin @(negedge clk); n += int'(tx_tick) + int'(rx_tick); end
        check("R8 silent after program reset", n, 0);
        ext_run(5, ntx, nrx);
        check("R8 back in ext mode tx", ntx, 5);
        check("R8 rx source restored", nrx, 5);

        repeat (5) @(negedge clk);
        report();
    end
endmodule